// File: doc/BRIEF.md
# GPIO Port with Pin-Change Interrupt

This block is a memory-mapped general-purpose I/O port of up to 32 pins, reached through a plain 32-bit register bus with a word index, a write strobe and a combinational read path. Software sets each pin's direction and output value, reads back the live pad levels, and is told about pin activity through one interrupt line.

Every pad input passes through a two-flop synchroniser. Any change of a synchronised level, rising or falling, latches a sticky per-pin change bit, which software acknowledges by writing a one to that bit. The interrupt line is high while at least one change bit is set whose pin is unmasked in the enable register. Two further register slots, a write mask and a trigger-type selector, are reserved: they read as zero and ignore writes, since only both-edge detection exists.

Top module: `gpio_change_irq`

## Requirements
- R1: After a synchronous active-low reset, the direction, output data, enable and change registers all read zero, `pin_oe` and `pin_out` are zero and `irq_out` is low.
- R2: Word index 0 (byte offset 0x00) is the direction register; bit value 1 makes the pin an output (`pin_oe` high), 0 an input. A write shows on `pin_oe` after the clock edge that samples the strobe.
- R3: Writing word index 1 (offset 0x04) sets `pin_out` after the sampling edge; reading it returns the synchronised pad level of every pin, whatever the pin's direction, two rising edges after the pad changes.
- R4: A rising or a falling level on any pin sets that pin's bit in the change register (word index 3, offset 0x0C); the bit becomes visible after the third rising edge following the pad change and stays set until acknowledged.
- R5: Writing word index 3 clears each change bit whose data bit is 1; bits written as 0 keep their value.
- R6: If a new edge and an acknowledge of the same bit meet in one cycle, the edge wins and the bit stays set.
- R7: Word index 2 (offset 0x08) is the interrupt enable (1 = unmasked); `irq_out` is high exactly when change AND enable is non-zero.
- R8: Bits at and above `PIN_COUNT` read as zero in every register; word indices 4 and 5 (offsets 0x10, 0x14) read as zero and writes to them change nothing.
- R9: An edge on the pad of a pin configured as output still sets its change bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_widx | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_widx`, combinational |
| pin_in | input | PIN_COUNT | Pad input levels, asynchronous |
| pin_out | output | PIN_COUNT | Output data to pads |
| pin_oe | output | PIN_COUNT | Per-pin output enable (direction) |
| irq_out | output | 1 | Combined pin-change interrupt |

## Verification
The hardest situation to reach from the ports is an acknowledge write landing in the single cycle in which the edge detector reports a new edge on a bit that is already set. The stimulus first sets the bit with one pad toggle, then toggles the pad again and counts two rising edges for the synchroniser before issuing the clear, so the clear is sampled on the same edge that records the new edge. A table of pad patterns then walks single-pin, multi-pin, all-pin and falling transitions, checking level read-back and the change bits after each step.

// File: rtl/gpio_ci_pkg.sv
// Package: shared register indices and bus width for the GPIO port.
// Assumes a word-indexed register bus; index = byte offset / 4.
package gpio_ci_pkg;
    localparam int BUS_W  = 32;
    localparam int WIDX_W = 3;

    typedef enum logic [WIDX_W-1:0] {
        IDX_DIR   = 3'd0,   // pin direction, 1 = output
        IDX_DATA  = 3'd1,   // write: output value, read: pad level
        IDX_EN    = 3'd2,   // interrupt enable per pin
        IDX_CHG   = 3'd3,   // sticky change bits, write one to clear
        IDX_WMASK = 3'd4,   // reserved, reads zero
        IDX_TYPE  = 3'd5    // reserved, reads zero
    } reg_idx_e;
endpackage

// File: rtl/gpio_ci_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_ci_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the input one stage deeper per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ci_chg.sv
// Module: both-edge detector and sticky change register.
// Assumes lvl is already synchronous; clr_mask is zero except on an
// acknowledge write. A new edge outranks a clear of the same bit.
module gpio_ci_chg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] chg_q
);
    logic [WIDTH-1:0] lvl_prev_q;
    logic [WIDTH-1:0] edge_hit;

    // Purpose: remember last cycle's synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev_q <= '0;
        else        lvl_prev_q <= lvl;
    end

    // Purpose: flag any level difference as an edge.
    always_comb edge_hit = lvl ^ lvl_prev_q;

    // Purpose: latch edges, apply clears, let edges take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= (chg_q & ~clr_mask) | edge_hit;
    end
endmodule

// File: rtl/gpio_ci_regs.sv
// Module: direction, output and enable registers plus read mux and
// write decode for the change-register acknowledge.
// Assumes writes take effect on the edge that samples bus_we.
module gpio_ci_regs
    import gpio_ci_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] widx,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [WIDTH-1:0]  lvl,
    input  logic [WIDTH-1:0]  chg,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  out_q,
    output logic [WIDTH-1:0]  en_q,
    output logic [WIDTH-1:0]  clr_mask,
    output logic [BUS_W-1:0]  rdata
);
    logic [WIDTH-1:0] wbits;
    assign wbits = wdata[WIDTH-1:0];

    generate
        if (WIDTH < BUS_W) begin : g_unused_hi
            logic unused_hi;
            assign unused_hi = ^wdata[BUS_W-1:WIDTH];
        end
    endgenerate

    // Purpose: hold the three software-owned registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            en_q  <= '0;
        end else if (wr_en) begin
            case (widx)
                IDX_DIR:  dir_q <= wbits;
                IDX_DATA: out_q <= wbits;
                IDX_EN:   en_q  <= wbits;
                default:  ;
            endcase
        end
    end

    // Purpose: turn a write to the change register into a clear mask.
    always_comb clr_mask = (wr_en && widx == IDX_CHG) ? wbits : '0;

    // Purpose: select read data, zero-extended above WIDTH.
    always_comb begin
        rdata = '0;
        case (widx)
            IDX_DIR:  rdata[WIDTH-1:0] = dir_q;
            IDX_DATA: rdata[WIDTH-1:0] = lvl;
            IDX_EN:   rdata[WIDTH-1:0] = en_q;
            IDX_CHG:  rdata[WIDTH-1:0] = chg;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_change_irq.sv
// Module: top of the GPIO port with pin-change interrupt.
// Assumes PIN_COUNT in 1..32 and asynchronous pad inputs.
module gpio_change_irq
    import gpio_ci_pkg::*;
#(
    parameter int PIN_COUNT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [WIDX_W-1:0]    bus_widx,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq_out
);
    logic [PIN_COUNT-1:0] level_sync;
    logic [PIN_COUNT-1:0] change_q;
    logic [PIN_COUNT-1:0] enable_q;
    logic [PIN_COUNT-1:0] clear_mask;

    gpio_ci_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level_sync)
    );

    gpio_ci_chg #(.WIDTH(PIN_COUNT)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (level_sync),
        .clr_mask (clear_mask),
        .chg_q    (change_q)
    );

    gpio_ci_regs #(.WIDTH(PIN_COUNT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .widx     (bus_widx),
        .wdata    (bus_wdata),
        .lvl      (level_sync),
        .chg      (change_q),
        .dir_q    (pin_oe),
        .out_q    (pin_out),
        .en_q     (enable_q),
        .clr_mask (clear_mask),
        .rdata    (bus_rdata)
    );

    // Purpose: merge unmasked change bits into one interrupt line.
    always_comb irq_out = |(change_q & enable_q);
endmodule

// File: rtl/gpio_change_irq_chk.sv
// Module: property checker bound to gpio_change_irq.
// Assumes it observes the top's ports and its change/enable state.
module gpio_change_irq_chk #(
    parameter int PIN_COUNT = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [2:0]           bus_widx,
    input logic [31:0]          bus_wdata,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic                 irq_out,
    input logic [PIN_COUNT-1:0] chg,
    input logic [PIN_COUNT-1:0] en
);
    logic wr_dir, wr_data, wr_chg;
    assign wr_dir  = bus_we && bus_widx == 3'd0;
    assign wr_data = bus_we && bus_widx == 3'd1;
    assign wr_chg  = bus_we && bus_widx == 3'd3;

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(bus_wdata[PIN_COUNT-1:0]));

    p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> pin_out == $past(bus_wdata[PIN_COUNT-1:0]));

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_chg |=> (chg & $past(chg)) == $past(chg));

    p_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_chg |=> (chg & $past(chg & ~bus_wdata[PIN_COUNT-1:0]))
                   == $past(chg & ~bus_wdata[PIN_COUNT-1:0]));

    p_irq_needs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $countones(chg & en) > 0);

    p_irq_no_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg & en) == 0 |-> !irq_out);
endmodule

bind gpio_change_irq gpio_change_irq_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_widx  (bus_widx),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .chg       (change_q),
    .en        (enable_q)
);

// File: tb/gpio_change_irq_bench.sv
module gpio_change_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int NVEC = 8;
    localparam logic [N-1:0] PAD_SEQ [NVEC] = '{
        16'h0001, 16'h0000, 16'h8000, 16'h00F0,
        16'hFFFF, 16'h5A5A, 16'h0000, 16'h1234
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_widx = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;

    gpio_change_irq #(.PIN_COUNT(N)) u_gpio_change_irq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_widx(bus_widx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] idx, input logic [31:0] data);
        bus_we = 1'b1; bus_widx = idx; bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] idx, output logic [31:0] data);
        bus_widx = idx;
        #1;
        data = bus_rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [N-1:0] prev;
        settle(3);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(3'd0, rd); check("R1 dir", rd, 0);
        bus_read(3'd2, rd); check("R1 enable", rd, 0);
        bus_read(3'd3, rd); check("R1 change", rd, 0);
        check("R1 pin_out", 32'(pin_out), 0);
        check("R1 irq", 32'(irq_out), 0);

        // Table walk: R3 level read-back, R4 both-edge change bits
        prev = '0;
        for (int v = 0; v < NVEC; v++) begin
            pin_in = PAD_SEQ[v];
            settle(3);
            bus_read(3'd1, rd); check("R3 pad level", rd, 32'(PAD_SEQ[v]));
            bus_read(3'd3, rd); check("R4 change", rd, 32'(prev ^ PAD_SEQ[v]));
            bus_write(3'd3, 32'(prev ^ PAD_SEQ[v]));
            bus_read(3'd3, rd); check("R5 cleared", rd, 0);
            prev = PAD_SEQ[v];
        end

        // R3 level visible exactly two edges after a pad change
        pin_in = prev ^ 16'h0100;
        settle(1);
        bus_read(3'd1, rd); check("R3 not yet", rd, 32'(prev));
        settle(1);
        bus_read(3'd1, rd); check("R3 two edges", rd, 32'(prev ^ 16'h0100));
        settle(1);
        bus_write(3'd3, 32'hFFFF_FFFF);
        prev = prev ^ 16'h0100;

        // R2 / R8: direction with upper bits, R3 output data
        bus_write(3'd0, 32'hFFFF_00F0);
        check("R2 pin_oe", 32'(pin_oe), 32'h0000_00F0);
        bus_read(3'd0, rd); check("R8 dir upper zero", rd, 32'h0000_00F0);
        bus_write(3'd1, 32'hABCD_9876);
        check("R3 pin_out", 32'(pin_out), 32'h0000_9876);

        // R8 reserved slots
        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_write(3'd5, 32'hFFFF_FFFF);
        bus_read(3'd4, rd); check("R8 wmask reads zero", rd, 0);
        bus_read(3'd5, rd); check("R8 type reads zero", rd, 0);
        bus_read(3'd0, rd); check("R8 dir untouched", rd, 32'h0000_00F0);
        check("R8 pin_out untouched", 32'(pin_out), 32'h0000_9876);

        // R9: edge on an output pin (bit 4, direction output)
        pin_in = prev ^ 16'h0010;
        settle(3);
        bus_read(3'd3, rd); check("R9 output-pin edge", rd, 32'h0000_0010);
        prev = prev ^ 16'h0010;

        // R7: masked then unmasked
        check("R7 masked irq low", 32'(irq_out), 0);
        bus_write(3'd2, 32'h0000_0010);
        check("R7 unmasked irq high", 32'(irq_out), 1);
        bus_write(3'd2, 32'h0000_0001);
        check("R7 other mask irq low", 32'(irq_out), 0);
        bus_write(3'd2, 32'h0000_0010);

        // R5: write of zeros keeps the bit, one clears it
        bus_write(3'd3, 32'h0000_FFEF);
        bus_read(3'd3, rd); check("R5 zero keeps", rd, 32'h0000_0010);
        bus_write(3'd3, 32'h0000_0010);
        bus_read(3'd3, rd); check("R5 one clears", rd, 0);
        check("R7 irq drops after ack", 32'(irq_out), 0);

        // R6: clear and new edge in the same cycle
        pin_in = prev ^ 16'h0004;
        settle(3);
        prev = prev ^ 16'h0004;
        bus_read(3'd3, rd); check("R6 setup", rd, 32'h0000_0004);
        @(negedge clk);
        pin_in = prev ^ 16'h0004;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_write(3'd3, 32'h0000_0004);
        bus_read(3'd3, rd); check("R6 edge beats clear", rd, 32'h0000_0004);
        bus_write(3'd3, 32'h0000_0004);
        bus_read(3'd3, rd); check("R6 later clear", rd, 0);

        // R1: reset mid-run
        bus_write(3'd2, 32'h0000_FFFF);
        rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        pin_in = '0;
        check("R1 oe after reset", 32'(pin_oe), 0);
        check("R1 out after reset", 32'(pin_out), 0);
        bus_read(3'd2, rd); check("R1 enable after reset", rd, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule